// File: doc/BRIEF.md
# Column-Group Aligned Line Timing Generator

This block produces the per-line readout timing for an image sensor whose columns can only be read in fixed-size groups. Software supplies the first and last column of the region of interest, a line period in clocks, and a sensor-type select that sets the group size. At every line boundary the block snaps the read window outward to whole groups, so the region's first and last pixels are always read. It then holds line-valid high for one clock per group, with a column-group address that counts through the window. After that it idles until the line reaches the programmed period.

The programmed period cannot cut a line short. The shortest legal line is the group count plus a fixed four-clock overhead. When the setting is at or below that value, the shortest line is used and a flag reports it for that line. All settings are captured only at a line boundary, so a write made mid-line affects the next line. Dropping the enable lets the current line finish and stops further lines.

Top module: `line_timer`

## Requirements
- R1: With `sensor_sel`=0 the group size is 10 columns, and with `sensor_sel`=1 it is 16. Group number g covers columns g*size through g*size+size-1.
- R2: The first group read is floor(roi_first/size) and the last is floor(roi_last/size). `lval` is high for exactly (last-first+1) consecutive cycles per line.
- R3: In the first `lval` cycle of a line, `grp_addr` equals the first group, and it rises by one on each further `lval` cycle.
- R4: While `lval` is low, `grp_addr` holds its previous value.
- R5: `line_start` is high for exactly one cycle per line, in the same cycle as the first `lval` cycle.
- R6: The line length, measured between consecutive `line_start` pulses, is `line_period` when that exceeds groups+4. Otherwise it is groups+4. The `lval` width never depends on `line_period`.
- R7: `min_period_flag` is 1 for a line whose `line_period` is at or below groups+4 and 0 otherwise, and it is valid from that line's `line_start`.
- R8: All four settings are sampled only at a line boundary. Changes made during a line do not alter that line.
- R9: If `roi_last` is less than `roi_first`, the line reads the single group that contains `roi_first`.
- R10: A new line starts only if `en` is high at the boundary. After `en` falls, the current line completes and no new line starts. A line starts on the first boundary where `en` is seen high again.
- R11: During reset, `lval`, `line_start`, `grp_addr` and `min_period_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Permits new lines to start |
| sensor_sel | input | 1 | Group size select: 0 for 10 columns, 1 for 16 |
| roi_first | input | COL_W | First column of the region |
| roi_last | input | COL_W | Last column of the region |
| line_period | input | PER_W | Requested line length in clocks |
| lval | output | 1 | Line-valid window |
| grp_addr | output | COL_W | Column-group address being read |
| line_start | output | 1 | One-cycle pulse at the start of each line |
| min_period_flag | output | 1 | Shortest line length in force for this line |

## Verification
The bench targets columns that sit one either side of a group edge (9/10 and 15/16). A design that rounds the wrong way would produce one group too few and lose an edge pixel. It sets a period exactly equal to the minimum and one above it: an off-by-one comparison would flip the flag or give a line one clock off. A reversed region and a region of a single group both check that the group count never wraps to a huge value. Random settings rewritten in the middle of every line catch any setting that is not captured at the boundary, because such a setting would bend the running line. A period far below the minimum shows whether line-valid is being shortened. The enable test checks that turning lines off does not cut the current line short.

// File: rtl/line_timer_pkg.sv
package line_timer_pkg;
  typedef enum logic {
    GRP_TEN     = 1'b0,
    GRP_SIXTEEN = 1'b1
  } grp_kind_e;

  localparam int unsigned FIXED_OVH = 4;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q       <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      s1_q       <= 1'b1;
      rst_n_sync <= s1_q;
    end
  end
endmodule

// File: rtl/roi_align.sv
module roi_align
  import line_timer_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int CW    = 13,
  parameter int GRP_A = 10,
  parameter int GRP_B = 16
) (
  input  grp_kind_e          kind,
  input  logic [COL_W-1:0]   first_col,
  input  logic [COL_W-1:0]   last_col,
  output logic [COL_W-1:0]   start_grp,
  output logic [CW-1:0]      num_grp
);
  logic [COL_W-1:0] s_lane [2];
  logic [COL_W-1:0] e_lane [2];
  logic [COL_W-1:0] end_grp;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int GSZ = (g == 0) ? GRP_A : GRP_B;
    assign s_lane[g] = first_col / COL_W'(GSZ);
    assign e_lane[g] = last_col / COL_W'(GSZ);
  end

  always_comb begin
    start_grp = s_lane[kind];
    if (last_col < first_col) begin
      end_grp = start_grp;
    end else begin
      end_grp = e_lane[kind];
    end
    num_grp = CW'(end_grp) - CW'(start_grp) + CW'(1);
  end
endmodule

// File: rtl/period_sel.sv
module period_sel #(
  parameter int CW    = 13,
  parameter int PER_W = 12,
  parameter int OVH   = 4
) (
  input  logic [CW-1:0]    num_grp,
  input  logic [PER_W-1:0] period_req,
  output logic [CW-1:0]    period_eff,
  output logic             at_min
);
  logic [CW-1:0] min_p;
  logic [CW-1:0] req_w;

  always_comb begin
    min_p = num_grp + CW'(OVH);
    req_w = CW'(period_req);
    if (req_w > min_p) begin
      period_eff = req_w;
      at_min     = 1'b0;
    end else begin
      period_eff = min_p;
      at_min     = 1'b1;
    end
  end
endmodule

// File: rtl/line_seq.sv
module line_seq #(
  parameter int COL_W = 12,
  parameter int CW    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [COL_W-1:0] start_grp,
  input  logic [CW-1:0]    num_grp,
  input  logic [CW-1:0]    period_eff,
  input  logic             at_min,
  output logic             lval,
  output logic [COL_W-1:0] grp_addr,
  output logic             line_start,
  output logic             min_flag
);
  logic             active_q, active_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [COL_W-1:0] addr_q, addr_d;
  logic [CW-1:0]    ng_q;
  logic [CW-1:0]    per_q;
  logic             flag_q;
  logic             boundary;
  logic             load;

  always_comb begin
    boundary = !active_q || (cnt_q == per_q - CW'(1));
    load     = boundary && en;
    active_d = active_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    if (boundary) begin
      active_d = en;
      if (en) begin
        cnt_d  = '0;
        addr_d = start_grp;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
      if ((cnt_q + CW'(1)) < ng_q) begin
        addr_d = addr_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ng_q   <= '0;
      per_q  <= '0;
      flag_q <= 1'b0;
    end else if (load) begin
      ng_q   <= num_grp;
      per_q  <= period_eff;
      flag_q <= at_min;
    end
  end

  assign lval       = active_q && (cnt_q < ng_q);
  assign line_start = active_q && (cnt_q == '0);
  assign grp_addr   = addr_q;
  assign min_flag   = flag_q;
endmodule

// File: rtl/line_timer.sv
module line_timer
  import line_timer_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int PER_W = 12,
  parameter int GRP_A = 10,
  parameter int GRP_B = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sensor_sel,
  input  logic [COL_W-1:0] roi_first,
  input  logic [COL_W-1:0] roi_last,
  input  logic [PER_W-1:0] line_period,
  output logic             lval,
  output logic [COL_W-1:0] grp_addr,
  output logic             line_start,
  output logic             min_period_flag
);
  localparam int CW = ((COL_W > PER_W) ? COL_W : PER_W) + 1;

  logic             rst_n_i;
  logic [COL_W-1:0] start_grp;
  logic [CW-1:0]    num_grp;
  logic [CW-1:0]    period_eff;
  logic             at_min;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  roi_align #(.COL_W(COL_W), .CW(CW), .GRP_A(GRP_A), .GRP_B(GRP_B)) u_align (
    .kind      (grp_kind_e'(sensor_sel)),
    .first_col (roi_first),
    .last_col  (roi_last),
    .start_grp (start_grp),
    .num_grp   (num_grp)
  );

  period_sel #(.CW(CW), .PER_W(PER_W), .OVH(FIXED_OVH)) u_per (
    .num_grp    (num_grp),
    .period_req (line_period),
    .period_eff (period_eff),
    .at_min     (at_min)
  );

  line_seq #(.COL_W(COL_W), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .en         (en),
    .start_grp  (start_grp),
    .num_grp    (num_grp),
    .period_eff (period_eff),
    .at_min     (at_min),
    .lval       (lval),
    .grp_addr   (grp_addr),
    .line_start (line_start),
    .min_flag   (min_period_flag)
  );
endmodule

// File: rtl/line_timer_chk.sv
module line_timer_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lval,
  input logic          line_start,
  input logic [AW-1:0] grp_addr
);
  // R5
  start_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> lval);

  // R5
  rise_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lval) |-> line_start);

  // R5
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && !line_start) |-> (grp_addr == $past(grp_addr) + AW'(1)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lval |-> $stable(grp_addr));
endmodule

bind line_timer line_timer_chk #(.AW(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lval       (lval),
  .line_start (line_start),
  .grp_addr   (grp_addr)
);

// File: tb/tb_line_timer.sv
module tb_line_timer;
  localparam int COL_W = 12;
  localparam int PER_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic sensor_sel;
  logic [COL_W-1:0] roi_first, roi_last;
  logic [PER_W-1:0] line_period;
  logic lval, line_start, min_period_flag;
  logic [COL_W-1:0] grp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int c_sel, c_f, c_l, c_p;

  always #5 clk = ~clk;

  line_timer #(.COL_W(COL_W), .PER_W(PER_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sensor_sel(sensor_sel),
    .roi_first(roi_first), .roi_last(roi_last), .line_period(line_period),
    .lval(lval), .grp_addr(grp_addr), .line_start(line_start),
    .min_period_flag(min_period_flag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int grp_of(int s, int c);
    return (s != 0) ? c / 16 : c / 10;
  endfunction

  task automatic drive(int s, int f, int l, int p);
    sensor_sel  = s[0];
    roi_first   = COL_W'(f);
    roi_last    = COL_W'(l);
    line_period = PER_W'(p);
  endtask

  // Called at the negedge holding k=0 of a line; leaves at k=0 of the next.
  task automatic check_line(string tag, int ns, int nf, int nl, int np, bit drop_en);
    int sg, eg, ng, mn, per;
    bit fl;
    sg  = grp_of(c_sel, c_f);
    eg  = (c_l < c_f) ? sg : grp_of(c_sel, c_l);
    ng  = eg - sg + 1;
    mn  = ng + 4;
    per = (c_p > mn) ? c_p : mn;
    fl  = (c_p <= mn);
    for (int k = 0; k < per; k++) begin
      if (k > 0) @(negedge clk);
      chk({"R5/R6 line_start ", tag}, int'(line_start), (k == 0) ? 1 : 0);
      chk({"R2 lval ", tag}, int'(lval), (k < ng) ? 1 : 0);
      chk({"R1/R3/R4 grp_addr ", tag}, int'(grp_addr), sg + ((k < ng) ? k : ng - 1));
      if (k == 0) chk({"R7 flag ", tag}, int'(min_period_flag), int'(fl));
      if (k == 1) begin
        drive(ns, nf, nl, np);
        if (drop_en) en = 1'b0;
      end
    end
    c_sel = ns; c_f = nf; c_l = nl; c_p = np;
    @(negedge clk);
  endtask

  int ds[8] = '{0, 1, 1, 0, 0, 0, 1, 0};
  int df[8] = '{9, 15, 32, 50, 100, 100, 0, 319};
  int dl[8] = '{10, 16, 47, 20, 199, 199, 255, 319};
  int dp[8] = '{0, 0, 30, 40, 14, 15, 3, 8};
  string dt[8] = '{"R1 edge10", "R1 edge16", "R6 long", "R9 reversed",
                   "R7 at_min", "R7 above_min", "R6 no_shorten", "R2 single"};

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    en    = 1'b0;
    drive(ds[0], df[0], dl[0], dp[0]);
    c_sel = ds[0]; c_f = df[0]; c_l = dl[0]; c_p = dp[0];
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 lval", int'(lval), 0);
    chk("R11 line_start", int'(line_start), 0);
    chk("R11 grp_addr", int'(grp_addr), 0);
    chk("R11 flag", int'(min_period_flag), 0);
    rst_n = 1'b1;
    en    = 1'b1;
    for (int w = 0; w < 10 && !line_start; w++) @(negedge clk);
    chk("R10 first line started", int'(line_start), 1);

    // Directed corners; the last slot hands over to random settings (R8).
    for (int i = 0; i < 8; i++) begin
      if (i < 7) check_line(dt[i], ds[i+1], df[i+1], dl[i+1], dp[i+1], 1'b0);
      else check_line(dt[i], int'($urandom_range(0, 1)), int'($urandom_range(0, 319)),
                      int'($urandom_range(0, 319)), int'($urandom_range(0, 70)), 1'b0);
    end
    for (int i = 0; i < 150; i++) begin
      check_line("R8 random", int'($urandom_range(0, 1)), int'($urandom_range(0, 319)),
                 int'($urandom_range(0, 319)), int'($urandom_range(0, 70)), 1'b0);
    end

    // R10: drop enable mid-line; line completes, then nothing starts.
    check_line("R10 drop", 0, 40, 79, 20, 1'b1);
    begin
      int held;
      held = int'(grp_addr);
      for (int k = 0; k < 30; k++) begin
        chk("R10 idle line_start", int'(line_start), 0);
        chk("R10 idle lval", int'(lval), 0);
        chk("R4 idle grp_addr", int'(grp_addr), held);
        @(negedge clk);
      end
    end
    en = 1'b1;
    @(negedge clk);
    chk("R10 restart line_start", int'(line_start), 1);
    check_line("R10 restart", 0, 40, 79, 20, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule